// File: doc/BRIEF.md
# Configurable Interrupt Aggregator

This block gathers a set of internal event conditions and merges them into one interrupt line for a host. Each source has its own trigger sensitivity: a rising edge, a falling edge, or the level of the condition. A per-source enable bit decides whether that source can drive the line. The status of every source can always be read, whatever its enable bit. The host acknowledges an edge-triggered source by writing a one to that source's bit in the clear vector.

Every condition input passes through one register stage before detection. Each source then runs a two-state tracker. `ST_IDLE` moves to `ST_PEND` on `T_EDGE_SET`, which is a matching edge in edge mode, or on `T_LVL_ON`, which is the condition being high in level mode. `ST_PEND` moves back to `ST_IDLE` on `T_ACK`, which is a clear write in edge mode with no new edge, or on `T_LVL_OFF`, which is the condition going low in level mode. `ST_PEND` stays where it is on `T_SET_WINS`, which is an edge arriving in the same cycle as a clear. The line driver turns the merged request into a pin value and a pin output enable. The pin can be active-low, active-high, or open-drain active-low so that several devices can share one wired-OR line.

Top module: `irq_agg`

## Requirements
- R1: While reset is held and after it is released with all conditions low, `status_o` is all zeros, and in mode 00 the pin shows its inactive level (`int_o`=1, `int_oe_o`=1).
- R2: With sensitivity code 00 (rising), a 0-to-1 change on `cond_i[i]` sets `status_o[i]` at the second rising clock edge after the change. A 1-to-0 change sets nothing.
- R3: With sensitivity code 01 (falling), a 1-to-0 change on `cond_i[i]` sets `status_o[i]` at the second clock edge after the change. A 0-to-1 change sets nothing.
- R4: With sensitivity code 10 or 11 (level), `status_o[i]` follows `cond_i[i]` two clock edges later, and `clr_i[i]` has no effect on it.
- R5: In edge modes a set status bit stays set until a cycle in which `clr_i[i]` is 1. A clear bit of 0 leaves the status bit unchanged.
- R6: When an edge is detected in the same cycle as `clr_i[i]`=1, the status bit stays set.
- R7: A source whose `en_i[i]` is 0 still records into `status_o[i]` but does not assert the pin.
- R8: Pin mode 00 (active-low push-pull): `int_oe_o` is always 1, and `int_o` is 0 exactly when any bit of `status_o & en_i` is 1.
- R9: Pin mode 01 (active-high push-pull): `int_oe_o` is always 1, and `int_o` is 1 exactly when any bit of `status_o & en_i` is 1.
- R10: Pin mode 10 or 11 (open-drain): `int_o` is always 0, and `int_oe_o` is 1 exactly when any bit of `status_o & en_i` is 1.
- R11: The pin outputs change in the same cycle as the status bits that cause the change, with no extra register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cond_i | input | N_SRC | Raw event conditions |
| sens_i | input | 2*N_SRC | Sensitivity, two bits per source: 00 rise, 01 fall, 1x level |
| en_i | input | N_SRC | Per-source enable (1 = may drive the pin) |
| pol_mode_i | input | 2 | Pin mode: 00 low push-pull, 01 high push-pull, 1x open-drain low |
| clr_i | input | N_SRC | Write-one-to-clear strobe per source |
| status_o | output | N_SRC | Per-source status bits |
| int_o | output | 1 | Interrupt pin value |
| int_oe_o | output | 1 | Interrupt pin output enable |

## Verification
Rising, falling and level sources are each given both directions of change, so the tests can tell a correct edge polarity from a swapped one or from edge detection that is missing. Clears are written to the wrong bit, to a level source while its condition is high, and in the same cycle as a fresh edge. These cases separate a sticky status bit from a bit that clears on any write, and check that a set wins over a clear. The same pending pattern is then viewed through each pin mode and through a disabled source, which separates polarity, drive style and the enable gating.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Per-source trigger sensitivity code
    typedef enum logic [1:0] {
        SENS_RISE    = 2'b00,
        SENS_FALL    = 2'b01,
        SENS_LVL     = 2'b10,
        SENS_LVL_ALT = 2'b11
    } sens_e;

    // Interrupt pin drive style
    typedef enum logic [1:0] {
        PIN_LOW_PP     = 2'b00,
        PIN_HIGH_PP    = 2'b01,
        PIN_LOW_OD     = 2'b10,
        PIN_LOW_OD_ALT = 2'b11
    } pin_mode_e;

    // Per-source tracker state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } src_st_e;

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_agg_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cond_i,
    input  logic [1:0] sens_i,
    input  logic       clr_i,
    output logic       pend_o
);

    logic    cond_q, prev_q;
    logic    hit, level;
    sens_e   sel;
    src_st_e st_q, st_d;

    // Input stage and edge history
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cond_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            cond_q <= cond_i;
            prev_q <= cond_q;
        end
    end

    // Edge qualification per sensitivity
    always_comb begin
        sel   = sens_e'(sens_i);
        hit   = 1'b0;
        level = 1'b0;
        unique case (sel)
            SENS_RISE:    hit = cond_q & ~prev_q;
            SENS_FALL:    hit = ~cond_q & prev_q;
            SENS_LVL,
            SENS_LVL_ALT: level = 1'b1;
        endcase
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (level) begin
                    if (cond_q) st_d = ST_PEND;        // T_LVL_ON
                end else if (hit) begin
                    st_d = ST_PEND;                    // T_EDGE_SET
                end
            end
            ST_PEND: begin
                if (level) begin
                    if (!cond_q) st_d = ST_IDLE;       // T_LVL_OFF
                end else if (hit) begin
                    st_d = ST_PEND;                    // T_SET_WINS
                end else if (clr_i) begin
                    st_d = ST_IDLE;                    // T_ACK
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= ST_IDLE;
        else         st_q <= st_d;
    end

    // Output process
    always_comb pend_o = (st_q == ST_PEND);

endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
    import irq_agg_pkg::*;
(
    input  logic       active_i,
    input  logic [1:0] mode_i,
    output logic       pin_o,
    output logic       oe_o
);

    pin_mode_e mode;

    always_comb begin
        mode  = pin_mode_e'(mode_i);
        pin_o = 1'b0;
        oe_o  = 1'b1;
        unique case (mode)
            PIN_LOW_PP:  pin_o = ~active_i;
            PIN_HIGH_PP: pin_o = active_i;
            PIN_LOW_OD,
            PIN_LOW_OD_ALT: begin
                pin_o = 1'b0;
                oe_o  = active_i;
            end
        endcase
    end

endmodule

// File: rtl/irq_agg.sv
module irq_agg #(
    parameter int N_SRC = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_SRC-1:0]   cond_i,
    input  logic [2*N_SRC-1:0] sens_i,
    input  logic [N_SRC-1:0]   en_i,
    input  logic [1:0]         pol_mode_i,
    input  logic [N_SRC-1:0]   clr_i,
    output logic [N_SRC-1:0]   status_o,
    output logic               int_o,
    output logic               int_oe_o
);

    localparam int SENS_W = 2;

    logic [N_SRC-1:0] pend;
    logic             any_active;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        irq_src_cell u_cell (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .cond_i (cond_i[g]),
            .sens_i (sens_i[g*SENS_W +: SENS_W]),
            .clr_i  (clr_i[g]),
            .pend_o (pend[g])
        );
    end

    assign status_o   = pend;
    assign any_active = |(pend & en_i);

    irq_pin_drive u_pin (
        .active_i (any_active),
        .mode_i   (pol_mode_i),
        .pin_o    (int_o),
        .oe_o     (int_oe_o)
    );

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
    parameter int N_SRC = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [2*N_SRC-1:0] sens_i,
    input logic [N_SRC-1:0]   en_i,
    input logic [1:0]         pol_mode_i,
    input logic [N_SRC-1:0]   clr_i,
    input logic [N_SRC-1:0]   status_o,
    input logic               int_o,
    input logic               int_oe_o
);

    // R10: open-drain never drives high
    a_r10_od_never_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pol_mode_i[1] |-> (int_o == 1'b0));

    // R10: open-drain releases when nothing enabled is pending
    a_r10_od_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pol_mode_i[1] && ((status_o & en_i) == '0)) |-> !int_oe_o);

    // R7/R8: disabled or absent sources keep active-low pin inactive
    a_r7_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pol_mode_i == 2'b00) && ((status_o & en_i) == '0)) |-> (int_o && int_oe_o));

    // R9: active-high pin tracks enabled pending status
    a_r9_active_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pol_mode_i == 2'b01) |-> (int_oe_o && (int_o == |(status_o & en_i))));

    // R5: edge-mode status holds without a clear
    for (genvar i = 0; i < N_SRC; i++) begin : g_sticky
        a_r5_edge_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (status_o[i] && (sens_i[2*i +: 2] inside {2'b00, 2'b01}) && !clr_i[i])
            |=> status_o[i]);
    end

endmodule

bind irq_agg irq_agg_chk #(.N_SRC(N_SRC)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sens_i     (sens_i),
    .en_i       (en_i),
    .pol_mode_i (pol_mode_i),
    .clr_i      (clr_i),
    .status_o   (status_o),
    .int_o      (int_o),
    .int_oe_o   (int_oe_o)
);

// File: tb/irq_agg_tb.sv
module irq_agg_tb_top;

    localparam int  N          = 8;
    localparam time CLK_PERIOD = 10ns;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [N-1:0]   cond;
    logic [2*N-1:0] sens;
    logic [N-1:0]   en;
    logic [1:0]     mode;
    logic [N-1:0]   clr;
    logic [N-1:0]   status;
    logic           int_pin, int_oe;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    typedef struct {
        string        req;
        logic [N-1:0] st;
        logic         pin;
        logic         oe;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_agg #(.N_SRC(N)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cond_i     (cond),
        .sens_i     (sens),
        .en_i       (en),
        .pol_mode_i (mode),
        .clr_i      (clr),
        .status_o   (status),
        .int_o      (int_pin),
        .int_oe_o   (int_oe)
    );

    // Driver: push the expectation for the next rising edge, then move on
    task automatic step(input string req, input logic [N-1:0] est);
        exp_t e;
        logic act;
        act   = |(est & en);
        e.req = req;
        e.st  = est;
        unique case (mode)
            2'b00:   begin e.pin = ~act; e.oe = 1'b1; end
            2'b01:   begin e.pin = act;  e.oe = 1'b1; end
            default: begin e.pin = 1'b0; e.oe = act;  end
        endcase
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare after each rising edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_tests++;
            if (status !== e.st || int_pin !== e.pin || int_oe !== e.oe) begin
                n_fail++;
                $display("FAIL %s: status=%h int=%b oe=%b expected status=%h int=%b oe=%b",
                         e.req, status, int_pin, int_oe, e.st, e.pin, e.oe);
            end
        end
    end

    initial begin
        rst_n = 1'b0; cond = '0; sens = '0; en = '1; mode = 2'b00; clr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1", 8'h00);

        // R2 rising edge, two-edge latency; falling ignored
        cond = 8'h01; step("R2", 8'h00); step("R8", 8'h01);
        cond = 8'h00; step("R2", 8'h01); step("R5", 8'h01);
        // R5 clear on another bit, then own bit
        clr = 8'h02; step("R5", 8'h01);
        clr = 8'h01; step("R5", 8'h00);
        clr = 8'h00; step("R5", 8'h00);

        // R3 falling edge on source 1
        sens = 16'h0004;
        cond = 8'h02; step("R3", 8'h00); step("R3", 8'h00);
        cond = 8'h00; step("R3", 8'h00); step("R3", 8'h02);
        clr = 8'h02; step("R3", 8'h00);
        clr = 8'h00;

        // R4 level on source 2 (code 10), clear ignored
        sens = 16'h0024;
        cond = 8'h04; step("R4", 8'h00); step("R4", 8'h04);
        clr = 8'h04; step("R4", 8'h04); step("R4", 8'h04);
        clr = 8'h00;
        cond = 8'h00; step("R4", 8'h04); step("R4", 8'h00);
        // R4 level on source 3 (code 11)
        sens = 16'h00E4;
        cond = 8'h08; step("R4", 8'h00); step("R4", 8'h08);
        cond = 8'h00; step("R4", 8'h08); step("R4", 8'h00);

        // R6 set wins over simultaneous clear on source 0
        cond = 8'h01; step("R2", 8'h00); step("R2", 8'h01);
        cond = 8'h00; step("R6", 8'h01);
        cond = 8'h01; step("R6", 8'h01);
        clr = 8'h01;  step("R6", 8'h01);
        clr = 8'h00;  step("R6", 8'h01);
        clr = 8'h01;  step("R5", 8'h00);
        clr = 8'h00;

        // R7 disabled source records but stays off the pin
        cond = 8'h05; en = 8'hFB;
        step("R7", 8'h00); step("R7", 8'h04);
        en = 8'hFF; step("R11", 8'h04);

        // R9 active-high
        mode = 2'b01; step("R9", 8'h04);
        cond = 8'h01; step("R9", 8'h04); step("R9", 8'h00);

        // R10 open-drain, both codes
        mode = 2'b10; cond = 8'h05;
        step("R10", 8'h00); step("R10", 8'h04);
        mode = 2'b11; step("R10", 8'h04);
        cond = 8'h01; step("R10", 8'h04); step("R10", 8'h00);

        @(posedge clk); #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule